// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller for sixteen pads arranged as two banks of eight. Software reaches it through a plain byte-wide register bus with address, write data, a write strobe and a read strobe. Each pin has two registers of its own. The output-control register sets the direction, the drive type, the pull configuration and the driven level. The input-control register returns the synchronized pad level and holds the interrupt edge selection.

The pad inputs pass through a synchronizer before any use. Each pin compares its synchronized level with the level one clock earlier. When the configured edge occurs, a sticky pending bit for that pin is set. Pending bits are grouped per bank into status registers. Software acknowledges interrupts by writing back the value it just read, because each 1 written clears that bit.

A per-bank mask register gates the pending bits onto a single combined interrupt output. A second per-bank mask register is kept as plain read/write storage for a stand-by context. The pull configuration of each pin is brought out as ordinary outputs for the pad cells. The block does not model the resistors themselves.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Pin n (0..15) has an output-control register at address 0x2B+n for n<8 and 0x3B+(n-8) for n>=8. It stores write-data bits 5:0 and reads back {2'b00, stored bits}.
- R2: Output-control bit 5 set to 1 selects output and bit 0 is the level. With bit 4 = 0 (push-pull), pad_oe[n] equals bit 5 and pad_out[n] equals bit 0. With bit 5 = 0, pad_oe[n] is 0.
- R3: With bit 4 = 1 (open-drain), pad_out[n] is always 0. pad_oe[n] is 1 only while bit 5 is 1 and bit 0 is 0.
- R4: pull_en[n] follows output-control bit 3. pull_sel[2n+1:2n] follows bits 2:1 (0 strong down, 1 strong up, 2 weak down, 3 weak up). Both follow these bits whatever the direction is.
- R5: Pin n has an input-control register at 0x33+n for n<8 and 0x43+(n-8) for n>=8. It reads {5'b0, edge[1:0], level}. A write stores bits 2:1 only; write-data bit 0 is ignored. A pad_in change applied before clock edge k shows on the level bit after edge k+1.
- R6: The edge field encodes 0 = off, 1 = falling, 2 = rising and 3 = both. The configured edge of the synchronized level sets the pin's pending bit at the clock edge after the level bit changes. A pin with the field at 0 never sets its pending bit.
- R7: Pending status for pins 0..7 is read at 0x06 and for pins 8..15 at 0x07, one bit per pin at bit n mod 8. Writing a 1 clears that bit and writing a 0 leaves it unchanged, so writing back a read value acknowledges exactly those interrupts.
- R8: If an edge sets a pending bit in the same cycle that a write of 1 clears it, the bit ends up set.
- R9: Mask registers at 0x19 (pins 0..7) and 0x1A (pins 8..15) are read/write. A 1 at bit n mod 8 masks pin n. Masking does not stop the pending bit from being set.
- R10: Stand-by mask registers at 0x1B and 0x1C are read/write storage and have no effect on irq_out.
- R11: After reset all registers are zero, so every pin is an input with interrupts off and pad_oe, pull_en, pull_sel and irq_out are 0. bus_rdata is 0 at unmapped addresses and whenever bus_re is low.
- R12: irq_out is the OR over all sixteen pins of (pending AND NOT mask) and follows register changes in the same cycle, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_oe | output | 16 | Pad output enable per pin |
| pad_out | output | 16 | Pad driven level per pin |
| pull_en | output | 16 | Pull resistor enable per pin |
| pull_sel | output | 32 | Pull selection, two bits per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and the standard bank base addresses. Under these defaults every register of both banks can be reached, and the two-edge delay from pad to level bit can be predicted exactly. That delay lets the bench time pad toggles so they land on the same cycle as acknowledge writes, which exercises the set-over-clear priority. A free-running reference model follows all register writes and pad activity and is compared against every output on every clock. Random traffic then drives edge configurations, masks and clears in combinations the directed steps do not cover.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OCTL_BASE0  = 8'h2B,
  parameter logic [7:0] OCTL_BASE1  = 8'h3B,
  parameter logic [7:0] ICTL_BASE0  = 8'h33,
  parameter logic [7:0] ICTL_BASE1  = 8'h43,
  parameter logic [7:0] MASK_BASE   = 8'h19,
  parameter logic [7:0] SBMASK_BASE = 8'h1B,
  parameter logic [7:0] PEND_BASE   = 8'h06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [7:0]  bus_rdata,
  input  logic [15:0] pad_in,
  output logic [15:0] pad_oe,
  output logic [15:0] pad_out,
  output logic [15:0] pull_en,
  output logic [31:0] pull_sel,
  output logic        irq_out
);
  localparam int NPINS = 16;
  localparam int BANK  = 8;

  function automatic logic [7:0] pin_addr(input logic [7:0] b0, input logic [7:0] b1, input int i);
    return (i < BANK ? b0 : b1) + 8'(i % BANK);
  endfunction

  logic [5:0]  octl  [NPINS];
  logic [1:0]  iedge [NPINS];
  logic [7:0]  mask_a [2];
  logic [7:0]  mask_b [2];
  logic [15:0] pend;
  logic [15:0] sync_q [SYNC_STAGES];
  logic [15:0] lvl_q;

  logic [15:0] lvl, rise, fall, det, clr;
  logic [15:0] edge_en, dir_vec, od_vec, mask_vec;

  assign lvl      = sync_q[SYNC_STAGES-1];
  assign rise     = lvl & ~lvl_q;
  assign fall     = ~lvl & lvl_q;
  assign mask_vec = {mask_a[1], mask_a[0]};

  assign clr[7:0]  = (bus_we && bus_addr == PEND_BASE)      ? bus_wdata : 8'h00;
  assign clr[15:8] = (bus_we && bus_addr == PEND_BASE + 8'd1) ? bus_wdata : 8'h00;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      assign det[g]          = (iedge[g][0] & fall[g]) | (iedge[g][1] & rise[g]);
      assign edge_en[g]      = |iedge[g];
      assign dir_vec[g]      = octl[g][5];
      assign od_vec[g]       = octl[g][4];
      assign pad_oe[g]       = octl[g][5] & (~octl[g][4] | ~octl[g][0]);
      assign pad_out[g]      = octl[g][0] & ~octl[g][4];
      assign pull_en[g]      = octl[g][3];
      assign pull_sel[2*g+:2] = octl[g][2:1];
    end
  endgenerate

  assign irq_out = |(pend & ~mask_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      lvl_q <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      lvl_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) begin
        octl[i]  <= '0;
        iedge[i] <= '0;
      end
      for (int b = 0; b < 2; b++) begin
        mask_a[b] <= '0;
        mask_b[b] <= '0;
      end
      pend <= '0;
    end else begin
      pend <= (pend & ~clr) | det;
      if (bus_we) begin
        for (int i = 0; i < NPINS; i++) begin
          if (bus_addr == pin_addr(OCTL_BASE0, OCTL_BASE1, i)) octl[i]  <= bus_wdata[5:0];
          if (bus_addr == pin_addr(ICTL_BASE0, ICTL_BASE1, i)) iedge[i] <= bus_wdata[2:1];
        end
        for (int b = 0; b < 2; b++) begin
          if (bus_addr == MASK_BASE + 8'(b))   mask_a[b] <= bus_wdata;
          if (bus_addr == SBMASK_BASE + 8'(b)) mask_b[b] <= bus_wdata;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_re) begin
      for (int i = 0; i < NPINS; i++) begin
        if (bus_addr == pin_addr(OCTL_BASE0, OCTL_BASE1, i)) bus_rdata = {2'b00, octl[i]};
        if (bus_addr == pin_addr(ICTL_BASE0, ICTL_BASE1, i)) bus_rdata = {5'b0, iedge[i], lvl[i]};
      end
      for (int b = 0; b < 2; b++) begin
        if (bus_addr == MASK_BASE + 8'(b))   bus_rdata = mask_a[b];
        if (bus_addr == SBMASK_BASE + 8'(b)) bus_rdata = mask_b[b];
        if (bus_addr == PEND_BASE + 8'(b))   bus_rdata = pend[8*b+:8];
      end
    end
  end
endmodule

module gpio_edge_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [15:0] pend,
  input logic [15:0] edge_en,
  input logic [15:0] dir_vec,
  input logic [15:0] od_vec,
  input logic [15:0] mask_vec,
  input logic [15:0] pad_oe,
  input logic [15:0] pad_out,
  input logic        irq_out
);
  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((pend & $past(pend)) == $past(pend)));

  assert_off_never_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend & ~$past(pend)) & ~$past(edge_en)) == 16'h0));

  assert_irq_needs_unmasked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(pend & ~mask_vec)));

  assert_input_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_vec) == 16'h0);

  assert_od_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_vec) == 16'h0);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .pend(pend), .edge_en(edge_en),
  .dir_vec(dir_vec), .od_vec(od_vec), .mask_vec(mask_vec),
  .pad_oe(pad_oe), .pad_out(pad_out), .irq_out(irq_out)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] pad_in = 0;
  logic [15:0] pad_oe, pad_out, pull_en;
  logic [31:0] pull_sel;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pull_en(pull_en), .pull_sel(pull_sel),
    .irq_out(irq_out)
  );

  // reference model state
  int m_oct [16];
  int m_edge [16];
  int m_mask [2];
  int m_sb [2];
  bit [15:0] m_pend, p1, p2, p3;

  function automatic int oaddr(int n); return (n < 8) ? 'h2B + n : 'h3B + n - 8; endfunction
  function automatic int iaddr(int n); return (n < 8) ? 'h33 + n : 'h43 + n - 8; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_oct[i] = 0; m_edge[i] = 0; end
      m_mask[0] = 0; m_mask[1] = 0; m_sb[0] = 0; m_sb[1] = 0;
      m_pend = 0; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      bit [15:0] det, clr;
      det = 0; clr = 0;
      for (int i = 0; i < 16; i++) begin
        if (p2[i] && !p3[i] && (m_edge[i] == 2 || m_edge[i] == 3)) det[i] = 1;
        if (!p2[i] && p3[i] && (m_edge[i] == 1 || m_edge[i] == 3)) det[i] = 1;
      end
      if (bus_we) begin
        int a;
        a = bus_addr;
        if (a == 'h06) clr[7:0] = bus_wdata;
        if (a == 'h07) clr[15:8] = bus_wdata;
        for (int i = 0; i < 16; i++) begin
          if (a == oaddr(i)) m_oct[i] = bus_wdata % 64;
          if (a == iaddr(i)) m_edge[i] = (bus_wdata / 2) % 4;
        end
        if (a == 'h19) m_mask[0] = bus_wdata;
        if (a == 'h1A) m_mask[1] = bus_wdata;
        if (a == 'h1B) m_sb[0] = bus_wdata;
        if (a == 'h1C) m_sb[1] = bus_wdata;
      end
      m_pend = (m_pend & ~clr) | det;
      p3 = p2; p2 = p1; p1 = pad_in;
    end
  end

  function automatic int exp_rd(int a);
    if (!bus_re) return 0;
    for (int i = 0; i < 16; i++) begin
      if (a == oaddr(i)) return m_oct[i];
      if (a == iaddr(i)) return m_edge[i] * 2 + p2[i];
    end
    if (a == 'h19) return m_mask[0];
    if (a == 'h1A) return m_mask[1];
    if (a == 'h1B) return m_sb[0];
    if (a == 'h1C) return m_sb[1];
    if (a == 'h06) return m_pend[7:0];
    if (a == 'h07) return m_pend[15:8];
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (!bus_re) return "R11";
    if ((a >= 'h2B && a <= 'h32) || (a >= 'h3B && a <= 'h42)) return "R1";
    if ((a >= 'h33 && a <= 'h3A) || (a >= 'h43 && a <= 'h4A)) return "R5";
    if (a == 'h06 || a == 'h07) return "R6 R7 R8";
    if (a == 'h19 || a == 'h1A) return "R9";
    if (a == 'h1B || a == 'h1C) return "R10";
    return "R11";
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit [15:0] eoe, eout, epe;
      bit [31:0] eps;
      bit [15:0] mv;
      int er;
      for (int i = 0; i < 16; i++) begin
        bit dirb, odb, vb;
        dirb = m_oct[i][5]; odb = m_oct[i][4]; vb = m_oct[i][0];
        eoe[i]  = dirb && (!odb || !vb);
        eout[i] = vb && !odb;
        epe[i]  = m_oct[i][3];
        eps[2*i+:2] = m_oct[i][2:1];
      end
      mv = {m_mask[1][7:0], m_mask[0][7:0]};
      er = exp_rd(bus_addr);
      check(pad_oe == eoe, "R2 R3 pad_oe", pad_oe, eoe);
      check(pad_out == eout, "R2 R3 pad_out", pad_out, eout);
      check(pull_en == epe && pull_sel == eps, "R4 pull", {pull_en, pull_sel}, {epe, eps});
      check(irq_out == |(m_pend & ~mv), "R9 R12 irq", irq_out, |(m_pend & ~mv));
      check(bus_rdata == er[7:0], rd_tag(bus_addr), bus_rdata, er);
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(int a, int d);
    step(); bus_addr = a[7:0]; bus_wdata = d[7:0]; bus_we = 1; bus_re = 0;
    step(); bus_we = 0;
  endtask

  task automatic rd(int a);
    step(); bus_addr = a[7:0]; bus_re = 1; bus_we = 0;
    step(); bus_re = 0;
  endtask

  task automatic pads(int v, int wait_cyc);
    step(); pad_in = v[15:0];
    repeat (wait_cyc) step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset state, including read at a mapped address while held in reset
    #1; bus_re = 1; bus_addr = 8'h2B;
    repeat (3) @(posedge clk);
    #2; rst_n = 1; bus_re = 0;
    for (int i = 0; i < 16; i++) rd(oaddr(i));

    // R1 R2 R4: push-pull output, pull strong up, driving 1
    wr('h2B, 'h2B);
    // R3: open-drain pins, low and high
    wr('h2C, 'h30);
    wr('h2D, 'h31);
    // R4: input pin with weak up pull, R1 upper bits masked
    wr('h3B, 'hCE);
    wr('h42, 'h0D);
    rd('h2B); rd('h2C); rd('h2D); rd('h3B); rd('h42);
    wr('h2D, 'h30);  // open-drain now drives low

    // R5 R6: rising on pin0 (bit0 ignored), falling pin1, off pin8, both pin9
    wr('h33, 'h05);
    wr('h34, 'h02);
    wr('h43, 'h00);
    wr('h44, 'h06);
    rd('h33); rd('h34); rd('h44);
    // R9: mask all but pin0
    wr('h19, 'hFE); wr('h1A, 'hFF);

    pads('h0303, 4);   // R6: rise on pin0, pin1, pin8, pin9
    rd('h06); rd('h07); rd('h33);
    pads('h0000, 4);   // R6: falls
    rd('h06); rd('h07);
    // R7: write-back acknowledge
    wr('h06, 'h03); rd('h06);
    wr('h07, 'h00); rd('h07);
    wr('h07, 'h02); rd('h07);
    // R9 R12: unmask bank 1, R10 stand-by mask ignored for irq
    pads('h0200, 4);
    wr('h1B, 'hFF); wr('h1C, 'hFF); rd('h1B); rd('h1C);
    wr('h1A, 'h00); rd('h1A);
    wr('h1C, 'h00);
    wr('h07, 'h02);

    // R8: toggle pin9 every cycle while clearing it every cycle
    for (int k = 0; k < 12; k++) begin
      step(); pad_in = pad_in ^ 16'h0200;
      bus_addr = 8'h07; bus_wdata = 8'h02; bus_we = 1;
    end
    step(); bus_we = 0;
    rd('h07);
    wr('h07, 'hFF); wr('h06, 'hFF);

    // R11: unmapped reads
    rd('h00); rd('hFF); rd('h4B); rd('h1D); rd('h08);

    // random traffic over the full map
    for (int k = 0; k < 3000; k++) begin
      int sel, a;
      sel = $urandom_range(0, 9);
      step();
      if ($urandom_range(0, 3) == 0) pad_in = 16'($urandom);
      case (sel)
        0: a = oaddr($urandom_range(0, 15));
        1, 2: a = iaddr($urandom_range(0, 15));
        3: a = 'h06 + $urandom_range(0, 1);
        4: a = 'h19 + $urandom_range(0, 3);
        default: a = $urandom_range(0, 255);
      endcase
      bus_addr = a[7:0];
      bus_wdata = 8'($urandom);
      bus_we = ($urandom_range(0, 2) == 0);
      bus_re = !bus_we;
    end
    step(); bus_we = 0; bus_re = 0;
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule